// File: doc/BRIEF.md
# Seven-Segment Display Register Bank with Font Decoder

This block is the register file of an eight-digit seven-segment display controller. A serial front end, not part of this block, hands it one write per cycle as a 4-bit address and an 8-bit data byte. The bank keeps eight digit registers and a set of control registers. It passes the decoded control values on to the scan and brightness logic that follows.

For the digit picked by a 3-bit index, the block gives an 8-bit segment pattern. A per-digit mask chooses how the stored byte is used. The byte can drive the segments as it is, or its low nibble can be mapped through a fixed numeric font. In both cases the top data bit drives the decimal point. A soft-reset bit in the reset/clock register returns every other register to its power-up value. While that bit stays set, the other registers are held at those values.

Top module: `seg_display_regs`

## Requirements
- R1: A write to address n (1 to 8) stores the data byte in digit register n-1. From the next cycle on, with `digit_sel` equal to n-1, `seg_out` shows that digit.
- R2: When the mask bit (address 9) for the selected digit is 0, `seg_out` equals the stored byte. Bit 7 is DP, and bits 6 to 0 are segments A, B, C, D, E, F, G.
- R3: When the mask bit is 1, `seg_out[6:0]` is the glyph chosen by data bits 3:0, and data bits 6:4 have no effect. The glyphs for codes 0 to 15, as ABCDEFG in hex, are: 7E 30 6D 79 33 5B 5F 70 7F 7B 01 4F 37 0E 67 00. Codes 10 to 15 show dash, E, H, L, P and blank.
- R4: `seg_out[7]` equals data bit 7 of the selected digit, whether or not that digit is decoded.
- R5: Decode-mask bit n acts on digit n only.
- R6: After a write, the control outputs take the new values. `intensity` is bits 3:0 of address 0xA. `scan_limit` is bits 2:0 of address 0xB. `shutdown` is the inverse of bit 0 of address 0xC. `disp_test` is bit 0 of address 0xF. `ext_clk_sel` is bit 0 of address 0xE.
- R7: Synchronous reset clears every register. The outputs are then: `shutdown` 1, `scan_limit` 0, `intensity` 0, `disp_test` 0, `ext_clk_sel` 0, decoding off, and all digits 0.
- R8: A write to 0xE with bit 1 set returns all other registers to their R7 values on that edge. Register 0xE keeps the written value. While its bit 1 stays 1, writes to other addresses are dropped.
- R9: Writes to address 0 or 0xD change no register.
- R10: Every register can be written while `shutdown` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| digit_sel | input | 3 | Digit whose pattern drives `seg_out` |
| seg_out | output | 8 | Segment pattern {DP,A,B,C,D,E,F,G} |
| intensity | output | 4 | Brightness step |
| scan_limit | output | 3 | Index of the last scanned digit |
| shutdown | output | 1 | Display blanked when 1 |
| disp_test | output | 1 | Lamp test active |
| ext_clk_sel | output | 1 | External clock selected |

## Verification
A vector table walks all sixteen font codes through a decoded digit. Codes with bits 6:4 set show that the upper nibble is masked. Codes with bit 7 set show that the decimal point bypasses the font. Raw bytes through an undecoded digit check the segment bit order. Distinct bytes in all eight digits rule out mixed-up addresses, and a mask with a single bit set tells per-digit decoding apart from a global switch. Directed sequences cover reset, ignored addresses, the held soft reset with its dropped writes, and writes made during shutdown.

// File: rtl/segdisp_pkg.sv
package segdisp_pkg;

    localparam int DIGIT_COUNT = 8;
    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 4;
    localparam int SEL_W       = $clog2(DIGIT_COUNT);
    localparam int INT_W       = 4;
    localparam int GLYPH_W     = 7;
    localparam int CODE_W      = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_NOP    = 4'h0,
        A_DECODE = 4'h9,
        A_INTENS = 4'hA,
        A_SCAN   = 4'hB,
        A_POWER  = 4'hC,
        A_SPARE  = 4'hD,
        A_RSTCLK = 4'hE,
        A_TEST   = 4'hF
    } reg_addr_e;

    typedef struct packed {
        logic [DIGIT_COUNT-1:0] decode_mask;
        logic [INT_W-1:0]       intensity;
        logic [SEL_W-1:0]       scan_limit;
        logic                   run;
        logic                   test;
        logic                   ext_clk;
        logic                   hold;
    } ctrl_t;

    localparam ctrl_t CTRL_DEFAULT = '0;

    typedef struct packed {
        logic [DIGIT_COUNT-1:0] digit;
        logic                   decode;
        logic                   intens;
        logic                   scan;
        logic                   power;
        logic                   rstclk;
        logic                   test;
    } wsel_t;

    // Fixed numeric font, segments ordered A..G from MSB to LSB.
    function automatic logic [GLYPH_W-1:0] glyph(input logic [CODE_W-1:0] code);
        logic [GLYPH_W-1:0] g;
        case (code)
            4'h0: g = 7'h7E;
            4'h1: g = 7'h30;
            4'h2: g = 7'h6D;
            4'h3: g = 7'h79;
            4'h4: g = 7'h33;
            4'h5: g = 7'h5B;
            4'h6: g = 7'h5F;
            4'h7: g = 7'h70;
            4'h8: g = 7'h7F;
            4'h9: g = 7'h7B;
            4'hA: g = 7'h01;
            4'hB: g = 7'h4F;
            4'hC: g = 7'h37;
            4'hD: g = 7'h0E;
            4'hE: g = 7'h67;
            default: g = 7'h00;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/seg_addr_decode.sv
module seg_addr_decode
    import segdisp_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output wsel_t             wsel
);
    reg_addr_e addr_e;
    assign addr_e = reg_addr_e'(wr_addr);

    generate
        for (genvar g = 0; g < DIGIT_COUNT; g++) begin : g_dig
            assign wsel.digit[g] = wr_en && (wr_addr == ADDR_W'(g + 1));
        end
    endgenerate

    always_comb begin
        wsel.decode = 1'b0;
        wsel.intens = 1'b0;
        wsel.scan   = 1'b0;
        wsel.power  = 1'b0;
        wsel.rstclk = 1'b0;
        wsel.test   = 1'b0;
        if (wr_en) begin
            case (addr_e)
                A_DECODE: wsel.decode = 1'b1;
                A_INTENS: wsel.intens = 1'b1;
                A_SCAN:   wsel.scan   = 1'b1;
                A_POWER:  wsel.power  = 1'b1;
                A_RSTCLK: wsel.rstclk = 1'b1;
                A_TEST:   wsel.test   = 1'b1;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/seg_ctrl_regs.sv
module seg_ctrl_regs
    import segdisp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wsel_t             wsel,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl_q,
    output logic              clr_o
);
    logic soft_clr;
    assign soft_clr = wsel.rstclk && wr_data[1];
    // Clear on the soft-reset write itself and for as long as the bit stays set.
    assign clr_o    = soft_clr || ctrl_q.hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_DEFAULT;
        end else begin
            if (wsel.rstclk) begin
                ctrl_q.ext_clk <= wr_data[0];
                ctrl_q.hold    <= wr_data[1];
            end
            if (clr_o) begin
                ctrl_q.decode_mask <= '0;
                ctrl_q.intensity   <= '0;
                ctrl_q.scan_limit  <= '0;
                ctrl_q.run         <= 1'b0;
                ctrl_q.test        <= 1'b0;
            end else begin
                if (wsel.decode) ctrl_q.decode_mask <= wr_data[DIGIT_COUNT-1:0];
                if (wsel.intens) ctrl_q.intensity   <= wr_data[INT_W-1:0];
                if (wsel.scan)   ctrl_q.scan_limit  <= wr_data[SEL_W-1:0];
                if (wsel.power)  ctrl_q.run         <= wr_data[0];
                if (wsel.test)   ctrl_q.test        <= wr_data[0];
            end
        end
    end
endmodule

// File: rtl/seg_digit_store.sv
module seg_digit_store
    import segdisp_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic [DIGIT_COUNT-1:0] we,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [SEL_W-1:0]       rd_sel,
    output logic [DATA_W-1:0]      rd_data
);
    logic [DATA_W-1:0] mem [DIGIT_COUNT];

    generate
        for (genvar g = 0; g < DIGIT_COUNT; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst || clr)  mem[g] <= '0;
                else if (we[g])  mem[g] <= wr_data;
            end
        end
    endgenerate

    assign rd_data = mem[rd_sel];
endmodule

// File: rtl/seg_font_map.sv
module seg_font_map
    import segdisp_pkg::*;
(
    input  logic [DATA_W-1:0] raw,
    input  logic              decode,
    output logic [DATA_W-1:0] seg
);
    logic [GLYPH_W-1:0] body;
    always_comb begin
        body = decode ? glyph(raw[CODE_W-1:0]) : raw[GLYPH_W-1:0];
        seg  = {raw[DATA_W-1], body};
    end
endmodule

// File: rtl/seg_display_regs.sv
module seg_display_regs
    import segdisp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  digit_sel,
    output logic [DATA_W-1:0] seg_out,
    output logic [INT_W-1:0]  intensity,
    output logic [SEL_W-1:0]  scan_limit,
    output logic              shutdown,
    output logic              disp_test,
    output logic              ext_clk_sel
);
    wsel_t             wsel;
    ctrl_t             ctrl_q;
    logic              clr;
    logic [DATA_W-1:0] digit_raw;

    seg_addr_decode u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wsel    (wsel)
    );

    seg_ctrl_regs u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wsel    (wsel),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .clr_o   (clr)
    );

    seg_digit_store u_store (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .we      (wsel.digit),
        .wr_data (wr_data),
        .rd_sel  (digit_sel),
        .rd_data (digit_raw)
    );

    seg_font_map u_font (
        .raw    (digit_raw),
        .decode (ctrl_q.decode_mask[digit_sel]),
        .seg    (seg_out)
    );

    assign intensity   = ctrl_q.intensity;
    assign scan_limit  = ctrl_q.scan_limit;
    assign shutdown    = ~ctrl_q.run;
    assign disp_test   = ctrl_q.test;
    assign ext_clk_sel = ctrl_q.ext_clk;
endmodule

// File: rtl/seg_display_regs_chk.sv
module seg_display_regs_chk
    import segdisp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [INT_W-1:0]  intensity,
    input logic [SEL_W-1:0]  scan_limit,
    input logic              shutdown,
    input logic              disp_test,
    input logic              ext_clk_sel,
    input logic              hold
);
    // R7
    a_r7_reset_defaults: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (intensity == '0 && scan_limit == '0 && shutdown
                        && !disp_test && !ext_clk_sel));

    // R9
    a_r9_ignored_addr: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == 4'h0 || wr_addr == 4'hD)) |=>
        ($stable(intensity) && $stable(scan_limit) && $stable(shutdown)
         && $stable(disp_test) && $stable(ext_clk_sel)));

    // R8
    a_r8_soft_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 4'hE && wr_data[1]) |=>
        (intensity == '0 && scan_limit == '0 && shutdown && !disp_test));

    // R6
    a_r6_intensity_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 4'hA && !hold) |=>
        (intensity == $past(wr_data[INT_W-1:0])));

    // R10
    a_r10_scan_in_shutdown: assert property (@(posedge clk) disable iff (rst)
        (shutdown && wr_en && wr_addr == 4'hB && !hold) |=>
        (scan_limit == $past(wr_data[SEL_W-1:0])));
endmodule

bind seg_display_regs seg_display_regs_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .intensity   (intensity),
    .scan_limit  (scan_limit),
    .shutdown    (shutdown),
    .disp_test   (disp_test),
    .ext_clk_sel (ext_clk_sel),
    .hold        (ctrl_q.hold)
);

// File: tb/seg_display_regs_tb.sv
module seg_display_regs_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] digit_sel = '0;
    logic [7:0] seg_out;
    logic [3:0] intensity;
    logic [2:0] scan_limit;
    logic       shutdown, disp_test, ext_clk_sel;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    seg_display_regs u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .digit_sel(digit_sel), .seg_out(seg_out),
        .intensity(intensity), .scan_limit(scan_limit), .shutdown(shutdown),
        .disp_test(disp_test), .ext_clk_sel(ext_clk_sel)
    );

    // {decode, data, expected segments}
    localparam logic [16:0] VEC [0:23] = '{
        {1'b1, 8'h00, 8'h7E}, {1'b1, 8'h01, 8'h30}, {1'b1, 8'h02, 8'h6D},
        {1'b1, 8'h03, 8'h79}, {1'b1, 8'h04, 8'h33}, {1'b1, 8'h05, 8'h5B},
        {1'b1, 8'h06, 8'h5F}, {1'b1, 8'h07, 8'h70}, {1'b1, 8'h08, 8'h7F},
        {1'b1, 8'h09, 8'h7B}, {1'b1, 8'h0A, 8'h01}, {1'b1, 8'h0B, 8'h4F},
        {1'b1, 8'h0C, 8'h37}, {1'b1, 8'h0D, 8'h0E}, {1'b1, 8'h0E, 8'h67},
        {1'b1, 8'h0F, 8'h00}, {1'b1, 8'h75, 8'h5B}, {1'b1, 8'h42, 8'h6D},
        {1'b1, 8'h88, 8'hFF}, {1'b1, 8'h8F, 8'h80},
        {1'b0, 8'hA5, 8'hA5}, {1'b0, 8'h00, 8'h00}, {1'b0, 8'h7F, 8'h7F},
        {1'b0, 8'h80, 8'h80}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic seg_of(input logic [2:0] s, output logic [7:0] v);
        digit_sel = s;
        #1 v = seg_out;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R7: reset state
        chk("R7 intensity", {4'h0, intensity}, 8'h00);
        chk("R7 scan", {5'h0, scan_limit}, 8'h00);
        chk("R7 shutdown", {7'h0, shutdown}, 8'h01);
        chk("R7 test/ext", {6'h0, disp_test, ext_clk_sel}, 8'h00);
        seg_of(3'd5, v); chk("R7 digit", v, 8'h00);

        // Vector table: R2 raw order, R3 font, R4 decimal point
        foreach (VEC[i]) begin
            wr(4'h9, VEC[i][16] ? 8'h08 : 8'h00);
            wr(4'h4, VEC[i][15:8]);
            seg_of(3'd3, v);
            chk(VEC[i][16] ? (VEC[i][15] ? "R4" : "R3") : "R2", v, VEC[i][7:0]);
        end

        // R1: each address maps to its digit
        wr(4'h9, 8'h00);
        for (int i = 0; i < 8; i++) wr(4'(i + 1), 8'(i * 17 + 3));
        for (int i = 0; i < 8; i++) begin
            seg_of(3'(i), v); chk("R1", v, 8'(i * 17 + 3));
        end

        // R5: mask bit acts on its own digit only
        wr(4'h9, 8'h04);
        wr(4'h3, 8'h05);
        wr(4'h2, 8'h05);
        seg_of(3'd2, v); chk("R5 decoded", v, 8'h5B);
        seg_of(3'd1, v); chk("R5 raw", v, 8'h05);

        // R6: control outputs
        wr(4'hA, 8'hF7); chk("R6 intensity", {4'h0, intensity}, 8'h07);
        wr(4'hB, 8'hFD); chk("R6 scan", {5'h0, scan_limit}, 8'h05);
        wr(4'hC, 8'h01); chk("R6 shutdown", {7'h0, shutdown}, 8'h00);
        wr(4'hF, 8'h01); chk("R6 test", {7'h0, disp_test}, 8'h01);
        wr(4'hE, 8'h01); chk("R6 ext", {7'h0, ext_clk_sel}, 8'h01);

        // R9: ignored addresses
        wr(4'h0, 8'hFF);
        wr(4'hD, 8'hFF);
        chk("R9 intensity", {4'h0, intensity}, 8'h07);
        chk("R9 scan", {5'h0, scan_limit}, 8'h05);
        chk("R9 flags", {5'h0, shutdown, disp_test, ext_clk_sel}, 8'h03);
        seg_of(3'd2, v); chk("R9 digit2", v, 8'h5B);
        seg_of(3'd0, v); chk("R9 digit0", v, 8'h03);

        // R10: writes during shutdown
        wr(4'hC, 8'h00); chk("R10 shutdown", {7'h0, shutdown}, 8'h01);
        wr(4'h1, 8'h3C); seg_of(3'd0, v); chk("R10 digit", v, 8'h3C);
        wr(4'hB, 8'h02); chk("R10 scan", {5'h0, scan_limit}, 8'h02);

        // R8: soft reset, held state, release
        wr(4'hC, 8'h01);
        wr(4'hA, 8'h0C);
        wr(4'hE, 8'h03);
        chk("R8 intensity", {4'h0, intensity}, 8'h00);
        chk("R8 scan", {5'h0, scan_limit}, 8'h00);
        chk("R8 flags", {5'h0, shutdown, disp_test, ext_clk_sel}, 8'h05);
        seg_of(3'd0, v); chk("R8 digit", v, 8'h00);
        wr(4'hA, 8'h09); chk("R8 held", {4'h0, intensity}, 8'h00);
        wr(4'h1, 8'h11); seg_of(3'd0, v); chk("R8 held digit", v, 8'h00);
        wr(4'hE, 8'h00); chk("R8 ext kept", {7'h0, ext_clk_sel}, 8'h00);
        wr(4'hA, 8'h09); chk("R8 released", {4'h0, intensity}, 8'h09);

        // R7: reset after activity
        wr(4'hE, 8'h01);
        wr(4'h8, 8'h6E);
        do_reset();
        chk("R7 re intensity", {4'h0, intensity}, 8'h00);
        chk("R7 re flags", {5'h0, shutdown, disp_test, ext_clk_sel}, 8'h04);
        seg_of(3'd7, v); chk("R7 re digit", v, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule